// File: doc/BRIEF.md
# Wide Vector Operation Splitter

This block sits between an in-order issue queue and a half-width vector back end. Each accepted micro-operation carries a class and a tag. A full-width (512-bit) arithmetic operation is cut into a low and a high 256-bit half. Both halves go to two of four execution lanes in the same cycle. The operation is then tracked as a single entry, so one completion carries the original tag.

Memory operations use two 256-bit load ports and one 256-bit store port. A full-width load takes both load ports in one cycle. A full-width store sends its low half in the cycle it is accepted and its high half in a later cycle. Completion follows the high half.

Each port (lane, load or store) has a ready input that says it can take one half this cycle. The block drives a valid only where that ready is high. Every tracked operation completes a fixed `LAT` cycles after its last half is sent, so at most one completion arises per cycle.

Top module: `vsplit_top`

## Requirements
- R1: Class 1 (vector-512) sends its two halves in the acceptance cycle to the two lowest-indexed ready lanes. The lower-indexed lane gets the low half (`lane_hi_o`=0) and the other lane gets the high half (`lane_hi_o`=1). Both lanes carry the input tag.
- R2: Class 0 (vector-256) uses exactly one lane, the lowest-indexed ready lane, with `lane_hi_o`=0 and the input tag.
- R3: `in_rdy_o` is high only when every half the head operation needs at once is available: one ready lane for class 0, two for class 1, one ready load port for class 2, both load ports for class 3, and the store port for classes 4 and 5. No valid is ever driven on a port whose ready is low.
- R4: Each tracked operation produces exactly one completion, `comp_vld_o` with its original tag, `LAT` cycles after the cycle in which its last half was sent.
- R5: Class 2 (load-256) uses the lowest-indexed ready load port with `ld_hi_o`=0. Class 3 (load-512) uses both load ports in the same cycle, with port 1 carrying the high half.
- R6: Class 4 (store-256) sends one low half on the store port. Class 5 (store-512) sends its low half in the acceptance cycle. Its high half (`st_hi_o`=1, same tag) goes in the first later cycle with `st_rdy_i` high. `in_rdy_o` stays low until that high half has been sent.
- R7: The store port and the load ports are never valid in the same cycle.
- R8: Classes 6 and 7 are accepted whenever no store half is pending. They drive no port and produce no completion, and `err_o` is high for exactly the next cycle.
- R9: Reset clears a pending store half and all in-flight completions. After reset is released, none of them appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Issue request valid |
| in_rdy_o | output | 1 | Issue request accepted this cycle when valid |
| in_cls_i | input | 3 | Operation class (0..5 legal) |
| in_tag_i | input | TAG_W | Tracking tag |
| lane_rdy_i | input | NLANE | Per-lane availability |
| lane_vld_o | output | NLANE | Per-lane half issue |
| lane_hi_o | output | NLANE | Lane carries the high half |
| lane_tag_o | output | NLANE*TAG_W | Per-lane tag, lane i at bits i*TAG_W |
| ld_rdy_i | input | NLD | Per-load-port availability |
| ld_vld_o | output | NLD | Load half issue |
| ld_hi_o | output | NLD | Load port carries the high half |
| ld_tag_o | output | NLD*TAG_W | Per-load-port tag |
| st_rdy_i | input | 1 | Store port availability |
| st_vld_o | output | 1 | Store half issue |
| st_hi_o | output | 1 | Store half is the high half |
| st_tag_o | output | TAG_W | Store tag |
| comp_vld_o | output | 1 | Completion valid |
| comp_tag_o | output | TAG_W | Completed tag |
| err_o | output | 1 | Illegal class was discarded last cycle |

## Verification
The assertions take port readies as plain availability flags that need no handshake back. They also assume that the issue side holds nothing in flight across reset beyond what the block itself tracks. The bench draws readies, classes and valids freshly each cycle from a seeded generator, which never breaks those assumptions. Illegal classes are drawn at a low rate. Directed runs add a store-512 held off by a long store stall, wide operations that meet a single ready lane or load port, and a reset while a store half is pending.

// File: rtl/vsplit_pkg.sv
package vsplit_pkg;
  localparam int unsigned CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_V256 = 3'd0,
    CLS_V512 = 3'd1,
    CLS_L256 = 3'd2,
    CLS_L512 = 3'd3,
    CLS_S256 = 3'd4,
    CLS_S512 = 3'd5
  } op_cls_e;

  localparam logic [CLS_W-1:0] CLS_LAST = CLS_S512;
endpackage

// File: rtl/vsplit_pick.sv
// Picks the lowest one or two ready slots; the second slot carries the high half.
module vsplit_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] rdy_i,
  input  logic         need2_i,
  output logic [N-1:0] gnt_o,
  output logic [N-1:0] hi_o,
  output logic         ok_o
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] first, rest, second;

  always_comb begin
    first  = rdy_i & (~rdy_i + ONE);
    rest   = rdy_i & ~first;
    second = rest & (~rest + ONE);
    gnt_o  = need2_i ? (first | second) : first;
    hi_o   = need2_i ? second : '0;
    ok_o   = need2_i ? (|second) : (|first);
  end
endmodule

// File: rtl/vsplit_track.sv
// Fixed-latency completion tracker: one entry per tracked operation.
module vsplit_track #(
  parameter int unsigned LAT   = 3,
  parameter int unsigned TAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             done_o,
  output logic [TAG_W-1:0] done_tag_o
);
  logic [LAT-1:0] v_q;
  logic [TAG_W-1:0] t_q [LAT];

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[0] <= 1'b0;
          t_q[0] <= '0;
        end else begin
          v_q[0] <= push_i;
          t_q[0] <= tag_i;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[s] <= 1'b0;
          t_q[s] <= '0;
        end else begin
          v_q[s] <= v_q[s-1];
          t_q[s] <= t_q[s-1];
        end
      end
    end
  end

  assign done_o     = v_q[LAT-1];
  assign done_tag_o = t_q[LAT-1];
endmodule

// File: rtl/vsplit_top.sv
module vsplit_top
  import vsplit_pkg::*;
#(
  parameter int unsigned NLANE = 4,
  parameter int unsigned NLD   = 2,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned LAT   = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_vld_i,
  output logic                   in_rdy_o,
  input  logic [CLS_W-1:0]       in_cls_i,
  input  logic [TAG_W-1:0]       in_tag_i,
  input  logic [NLANE-1:0]       lane_rdy_i,
  output logic [NLANE-1:0]       lane_vld_o,
  output logic [NLANE-1:0]       lane_hi_o,
  output logic [NLANE*TAG_W-1:0] lane_tag_o,
  input  logic [NLD-1:0]         ld_rdy_i,
  output logic [NLD-1:0]         ld_vld_o,
  output logic [NLD-1:0]         ld_hi_o,
  output logic [NLD*TAG_W-1:0]   ld_tag_o,
  input  logic                   st_rdy_i,
  output logic                   st_vld_o,
  output logic                   st_hi_o,
  output logic [TAG_W-1:0]       st_tag_o,
  output logic                   comp_vld_o,
  output logic [TAG_W-1:0]       comp_tag_o,
  output logic                   err_o
);
  logic [NLANE-1:0] lane_gnt, lane_hi;
  logic [NLD-1:0]   ld_gnt, ld_hi;
  logic             lane_ok, ld_ok;
  logic             is_vec, is_ld, is_st, cls_ok, can, fire, push;
  logic             pend_q, err_q;
  logic [TAG_W-1:0] pend_tag_q, push_tag;

  vsplit_pick #(.N(NLANE)) u_lane_pick (
    .rdy_i  (lane_rdy_i),
    .need2_i(in_cls_i == CLS_V512),
    .gnt_o  (lane_gnt),
    .hi_o   (lane_hi),
    .ok_o   (lane_ok)
  );

  vsplit_pick #(.N(NLD)) u_ld_pick (
    .rdy_i  (ld_rdy_i),
    .need2_i(in_cls_i == CLS_L512),
    .gnt_o  (ld_gnt),
    .hi_o   (ld_hi),
    .ok_o   (ld_ok)
  );

  always_comb begin
    is_vec = (in_cls_i == CLS_V256) || (in_cls_i == CLS_V512);
    is_ld  = (in_cls_i == CLS_L256) || (in_cls_i == CLS_L512);
    is_st  = (in_cls_i == CLS_S256) || (in_cls_i == CLS_S512);
    cls_ok = in_cls_i <= CLS_LAST;
    unique case (1'b1)
      is_vec:  can = lane_ok;
      is_ld:   can = ld_ok;
      is_st:   can = st_rdy_i;
      default: can = 1'b1;  // illegal class: accepted and dropped
    endcase
  end

  // A pending store high half owns the issue slot until it goes out.
  assign in_rdy_o = !pend_q && can;
  assign fire     = in_vld_i && in_rdy_o;

  assign lane_vld_o = (fire && is_vec) ? lane_gnt : '0;
  assign lane_hi_o  = (fire && is_vec) ? lane_hi  : '0;
  assign ld_vld_o   = (fire && is_ld)  ? ld_gnt   : '0;
  assign ld_hi_o    = (fire && is_ld)  ? ld_hi    : '0;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane_tag
    assign lane_tag_o[i*TAG_W +: TAG_W] = in_tag_i;
  end
  for (genvar i = 0; i < NLD; i++) begin : g_ld_tag
    assign ld_tag_o[i*TAG_W +: TAG_W] = in_tag_i;
  end

  assign st_vld_o = pend_q ? st_rdy_i : (fire && is_st);
  assign st_hi_o  = pend_q;
  assign st_tag_o = pend_q ? pend_tag_q : in_tag_i;

  assign push     = (fire && cls_ok && (in_cls_i != CLS_S512)) || (pend_q && st_rdy_i);
  assign push_tag = pend_q ? pend_tag_q : in_tag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_tag_q <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= fire && !cls_ok;
      if (pend_q && st_rdy_i) begin
        pend_q <= 1'b0;
      end else if (fire && in_cls_i == CLS_S512) begin
        pend_q     <= 1'b1;
        pend_tag_q <= in_tag_i;
      end
    end
  end

  assign err_o = err_q;

  vsplit_track #(.LAT(LAT), .TAG_W(TAG_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push),
    .tag_i     (push_tag),
    .done_o    (comp_vld_o),
    .done_tag_o(comp_tag_o)
  );
endmodule

// File: rtl/vsplit_chk.sv
module vsplit_chk
  import vsplit_pkg::*;
#(
  parameter int unsigned NLANE = 4,
  parameter int unsigned NLD   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_vld_i,
  input logic             in_rdy_o,
  input logic [CLS_W-1:0] in_cls_i,
  input logic [NLANE-1:0] lane_rdy_i,
  input logic [NLANE-1:0] lane_vld_o,
  input logic [NLANE-1:0] lane_hi_o,
  input logic [NLD-1:0]   ld_rdy_i,
  input logic [NLD-1:0]   ld_vld_o,
  input logic             st_rdy_i,
  input logic             st_vld_o,
  input logic             err_o
);
  logic fire;
  assign fire = in_vld_i && in_rdy_o;

  // R1
  wide_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && in_cls_i == CLS_V512) |-> ($countones(lane_vld_o) == 2 && $countones(lane_hi_o) == 1));

  // R2
  narrow_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && in_cls_i == CLS_V256) |-> ($countones(lane_vld_o) == 1 && lane_hi_o == '0));

  // R3
  lane_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lane_vld_o & ~lane_rdy_i) == '0) && ((ld_vld_o & ~ld_rdy_i) == '0) && !(st_vld_o && !st_rdy_i));

  // R5
  ld_wide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && in_cls_i == CLS_L512) |-> (&ld_vld_o));

  // R6
  st_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && in_cls_i == CLS_S512) |=> !in_rdy_o);

  // R7
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_vld_o && (|ld_vld_o)));

  // R8
  err_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && in_cls_i > CLS_LAST) |=> err_o);
endmodule

bind vsplit_top vsplit_chk #(.NLANE(NLANE), .NLD(NLD)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_vld_i  (in_vld_i),
  .in_rdy_o  (in_rdy_o),
  .in_cls_i  (in_cls_i),
  .lane_rdy_i(lane_rdy_i),
  .lane_vld_o(lane_vld_o),
  .lane_hi_o (lane_hi_o),
  .ld_rdy_i  (ld_rdy_i),
  .ld_vld_o  (ld_vld_o),
  .st_rdy_i  (st_rdy_i),
  .st_vld_o  (st_vld_o),
  .err_o     (err_o)
);

// File: tb/sim_vsplit_top.sv
module sim_vsplit_top;
  localparam int CLK_P = 10;
  localparam int NLANE = 4;
  localparam int NLD   = 2;
  localparam int TAG_W = 6;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_vld_i = 1'b0;
  logic [2:0] in_cls_i = '0;
  logic [TAG_W-1:0] in_tag_i = '0;
  logic [NLANE-1:0] lane_rdy_i = '0;
  logic [NLD-1:0] ld_rdy_i = '0;
  logic st_rdy_i = 1'b0;
  logic in_rdy_o, st_vld_o, st_hi_o, comp_vld_o, err_o;
  logic [NLANE-1:0] lane_vld_o, lane_hi_o;
  logic [NLANE*TAG_W-1:0] lane_tag_o;
  logic [NLD-1:0] ld_vld_o, ld_hi_o;
  logic [NLD*TAG_W-1:0] ld_tag_o;
  logic [TAG_W-1:0] st_tag_o, comp_tag_o;

  always #(CLK_P/2) clk = ~clk;

  vsplit_top #(.NLANE(NLANE), .NLD(NLD), .TAG_W(TAG_W), .LAT(LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_vld_i(in_vld_i), .in_rdy_o(in_rdy_o),
    .in_cls_i(in_cls_i), .in_tag_i(in_tag_i), .lane_rdy_i(lane_rdy_i),
    .lane_vld_o(lane_vld_o), .lane_hi_o(lane_hi_o), .lane_tag_o(lane_tag_o),
    .ld_rdy_i(ld_rdy_i), .ld_vld_o(ld_vld_o), .ld_hi_o(ld_hi_o), .ld_tag_o(ld_tag_o),
    .st_rdy_i(st_rdy_i), .st_vld_o(st_vld_o), .st_hi_o(st_hi_o), .st_tag_o(st_tag_o),
    .comp_vld_o(comp_vld_o), .comp_tag_o(comp_tag_o), .err_o(err_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  bit m_pend = 1'b0, m_err = 1'b0;
  logic [TAG_W-1:0] m_ptag = '0;
  bit sched_v [64];
  logic [TAG_W-1:0] sched_t [64];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // lowest one or two set bits of a mask
  function automatic void pick(input int n, input int mask, input bit two,
                               output int gnt, output int hi, output bit ok);
    int f = -1, s = -1;
    for (int i = 0; i < n; i++) begin
      if (mask[i]) begin
        if (f < 0) f = i;
        else if (s < 0) s = i;
      end
    end
    gnt = 0; hi = 0;
    ok = two ? (s >= 0) : (f >= 0);
    if (ok) begin
      gnt = 1 << f;
      if (two) begin
        gnt |= (1 << s);
        hi = 1 << s;
      end
    end
  endfunction

  task automatic step(input bit v, input int c, input int t, input int lr, input int ldr, input bit sr);
    int lg, lh, dg, dh, e_lv, e_lh, e_dv, e_dh, idx;
    bit lok, dok, can, e_rdy, fire, e_sv, e_sh, push;
    int e_st;
    @(negedge clk);
    in_vld_i = v; in_cls_i = 3'(c); in_tag_i = TAG_W'(t);
    lane_rdy_i = NLANE'(lr); ld_rdy_i = NLD'(ldr); st_rdy_i = sr;
    #1;
    pick(NLANE, lr, c == 1, lg, lh, lok);
    pick(NLD, ldr, c == 3, dg, dh, dok);
    case (c)
      0, 1: can = lok;
      2, 3: can = dok;
      4, 5: can = sr;
      default: can = 1'b1;
    endcase
    e_rdy = !m_pend && can;
    chk(in_rdy_o == e_rdy, "R3", "in_rdy_o", in_rdy_o, e_rdy);
    fire = v && e_rdy;
    e_lv = (fire && c <= 1) ? lg : 0;
    e_lh = (fire && c <= 1) ? lh : 0;
    e_dv = (fire && (c == 2 || c == 3)) ? dg : 0;
    e_dh = (fire && (c == 2 || c == 3)) ? dh : 0;
    chk(lane_vld_o == NLANE'(e_lv), c == 1 ? "R1" : "R2", "lane_vld_o", lane_vld_o, e_lv);
    chk(lane_hi_o == NLANE'(e_lh), c == 1 ? "R1" : "R2", "lane_hi_o", lane_hi_o, e_lh);
    for (int i = 0; i < NLANE; i++)
      if (e_lv[i]) chk(lane_tag_o[i*TAG_W +: TAG_W] == TAG_W'(t), "R1", "lane_tag_o", lane_tag_o[i*TAG_W +: TAG_W], t);
    chk(ld_vld_o == NLD'(e_dv) && ld_hi_o == NLD'(e_dh), "R5", "ld_vld/hi", {ld_vld_o, ld_hi_o}, (e_dv << 2) | e_dh);
    if (m_pend) begin
      e_sv = sr; e_sh = 1'b1; e_st = m_ptag;
    end else begin
      e_sv = fire && (c == 4 || c == 5); e_sh = 1'b0; e_st = t;
    end
    chk(st_vld_o == e_sv, "R6", "st_vld_o", st_vld_o, e_sv);
    if (e_sv) chk(st_hi_o == e_sh && st_tag_o == TAG_W'(e_st), "R6", "st_hi/tag", {st_hi_o, st_tag_o}, {e_sh, TAG_W'(e_st)});
    chk(!(st_vld_o && |ld_vld_o), "R7", "store with load", {st_vld_o, ld_vld_o}, 0);
    idx = cyc % 64;
    chk(comp_vld_o == sched_v[idx], "R4", "comp_vld_o", comp_vld_o, sched_v[idx]);
    if (sched_v[idx]) chk(comp_tag_o == sched_t[idx], "R4", "comp_tag_o", comp_tag_o, sched_t[idx]);
    chk(err_o == m_err, "R8", "err_o", err_o, m_err);
    // model update
    sched_v[idx] = 1'b0;
    push = (fire && c <= 4) || (m_pend && sr);
    if (push) begin
      sched_v[(cyc + LAT) % 64] = 1'b1;
      sched_t[(cyc + LAT) % 64] = m_pend ? m_ptag : TAG_W'(t);
    end
    m_err = fire && c > 5;
    if (m_pend && sr) m_pend = 1'b0;
    else if (fire && c == 5) begin m_pend = 1'b1; m_ptag = TAG_W'(t); end
    cyc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; in_vld_i = 1'b0;
    #1;
    chk(comp_vld_o == 1'b0 && err_o == 1'b0 && st_vld_o == 1'b0, "R9", "outputs in reset",
        {comp_vld_o, err_o, st_vld_o}, 0);
    for (int i = 0; i < 64; i++) sched_v[i] = 1'b0;
    m_pend = 1'b0; m_err = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < 64; i++) begin sched_v[i] = 1'b0; sched_t[i] = '0; end
    do_reset();
    // R1 wide vector with lanes 1 and 3 ready
    step(1, 1, 5, 4'b1010, 2'b11, 1);
    // R3 wide vector with one ready lane is held
    step(1, 1, 6, 4'b0100, 2'b11, 1);
    // R2 narrow vector takes lowest ready lane
    step(1, 0, 7, 4'b1100, 2'b11, 1);
    // R5 wide load needs both ports
    step(1, 3, 8, 4'b1111, 2'b10, 1);
    step(1, 3, 8, 4'b1111, 2'b11, 1);
    step(1, 2, 9, 4'b1111, 2'b10, 1);
    // R6 wide store with store port stalled for three cycles
    step(1, 5, 10, 4'b1111, 2'b11, 1);
    step(1, 0, 11, 4'b1111, 2'b11, 0);
    step(1, 0, 11, 4'b1111, 2'b11, 0);
    step(1, 0, 11, 4'b1111, 2'b11, 0);
    step(1, 0, 11, 4'b1111, 2'b11, 1);
    step(1, 4, 12, 4'b1111, 2'b11, 1);
    // R8 illegal classes
    step(1, 6, 13, 4'b1111, 2'b11, 1);
    step(1, 7, 14, 4'b0000, 2'b00, 0);
    for (int i = 0; i < LAT + 1; i++) step(0, 0, 0, 4'b1111, 2'b11, 1);
    // R9 reset with a pending store half and completions in flight
    step(1, 0, 20, 4'b1111, 2'b11, 1);
    step(1, 5, 21, 4'b1111, 2'b11, 1);
    do_reset();
    for (int i = 0; i < LAT + 2; i++) step(0, 0, 0, 4'b1111, 2'b11, 0);
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int r, c;
      r = int'($urandom % 16);
      c = (r < 14) ? r % 6 : 6 + r % 2;
      step(($urandom % 8) != 0, c, int'($urandom % 64), int'($urandom % 16),
           int'($urandom % 4), ($urandom % 3) != 0);
    end
    for (int i = 0; i < LAT + 2; i++) step(0, 0, 0, 4'b1111, 2'b11, 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule